// File: doc/BRIEF.md
# Fractional-N Modulus Sequencer

This block generates, once per phase-detector cycle, the integer division ratio that a fractional-N feedback divider should use next. A first-order accumulator adds the fractional numerator each cycle and wraps at a programmable modulus. The modulus can be any value from 2 to 4095 and does not have to be a power of two. Each wrap makes the emitted ratio one higher than the integer part. Over time the average ratio equals INT + FRAC/MOD.

The block runs from a clock at twice the reference rate. A reference divider (1 to 15) together with a doubler select sets how often the phase-detector cycle, and so an update, occurs. Programming values are sampled only at an update, so they can be rewritten at any time. Reset and power-down clear all state.

Top module: `frac_n_seq`

## Requirements
- R1: An update occurs every P clocks, where P = R when the doubler select is 1 and P = 2·R when it is 0. Each update raises `n_strobe` for exactly the one clock in which the new `n_out` and `carry` first appear.
- R2: A reference divide value of 0 is treated as 1.
- R3: At each update the accumulator adds FRAC. If the sum reaches MOD or more, MOD is subtracted, `carry` is 1 and `n_out` is INT+1. Otherwise `carry` is 0 and `n_out` is INT.
- R4: With the programming held steady, the `n_out` values of any MOD consecutive updates sum to exactly MOD·INT + FRAC.
- R5: With FRAC = 0, every update gives `carry` = 0 and `n_out` = INT.
- R6: With FRAC equal to MOD, every update gives `carry` = 1 and `n_out` = INT+1.
- R7: Out-of-range programming is clamped. INT below 31 is used as 31, MOD below 2 is used as 2, and FRAC above the effective MOD is used as that MOD.
- R8: INT, FRAC, MOD, R and the doubler select take effect only at an update. Between updates `n_out` and `carry` hold their values whatever the inputs do.
- R9: An update whose effective MOD differs from the one used at the previous update restarts the accumulator from zero before adding FRAC.
- R10: While reset (`rst_n` = 0) or power-down (`pwr_dn` = 1) is active, `n_out`, `carry`, `n_strobe`, the accumulator and the cycle counter are zero. The first update follows P clocks after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down; clears state while high |
| dbl_en | input | 1 | Doubler select: 1 gives an update period of R clocks, 0 gives 2·R |
| ref_div | input | 4 | Reference divide value R |
| int_in | input | 8 | Integer part INT |
| frac_in | input | 12 | Fractional numerator FRAC |
| mod_in | input | 12 | Fractional modulus MOD |
| n_out | output | 9 | Division ratio for the current cycle |
| carry | output | 1 | Accumulator wrapped at the last update |
| n_strobe | output | 1 | One-clock pulse marking a new ratio |

## Verification
The hardest condition to reach is a full-modulus window at the largest modulus, 4095 updates, where the ratio reaches 256 and the 9-bit output is needed. The stimulus reaches it by setting the doubler with R = 0, so an update occurs on every clock, and holding INT = 255 long enough for several complete windows. A second hard case is a modulus change while the accumulator holds a residue. The stimulus shrinks MOD in the middle of a run, so a missing restart would produce out-of-range accumulator values and wrong carries.

// File: rtl/frac_n_seq.sv
module frac_n_seq #(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 12,
  parameter int R_W     = 4,
  parameter int INT_MIN = 31,
  parameter int MOD_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              dbl_en,
  input  logic [R_W-1:0]    ref_div,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [FRAC_W-1:0] mod_in,
  output logic [INT_W:0]    n_out,
  output logic              carry,
  output logic              n_strobe
);

  localparam int CNT_W = R_W + 1;
  localparam int ACC_W = FRAC_W + 1;
  localparam int N_W   = INT_W + 1;

  logic [INT_W-1:0]  int_eff;
  logic [FRAC_W-1:0] mod_eff, frac_eff, acc, mod_q, acc_base, acc_nxt;
  logic [R_W-1:0]    r_eff;
  logic [CNT_W-1:0]  period, cnt;
  logic [ACC_W-1:0]  sum;
  logic              tick, wrap;

  assign int_eff  = (int_in < INT_W'(INT_MIN)) ? INT_W'(INT_MIN) : int_in;
  assign mod_eff  = (mod_in < FRAC_W'(MOD_MIN)) ? FRAC_W'(MOD_MIN) : mod_in;
  assign frac_eff = (frac_in > mod_eff) ? mod_eff : frac_in;
  assign r_eff    = (ref_div == '0) ? R_W'(1) : ref_div;
  assign period   = dbl_en ? {1'b0, r_eff} : {r_eff, 1'b0};
  assign tick     = !pwr_dn && (cnt >= period - CNT_W'(1));

  assign acc_base = (mod_eff != mod_q) ? '0 : acc;
  assign sum      = {1'b0, acc_base} + {1'b0, frac_eff};
  assign wrap     = sum >= {1'b0, mod_eff};
  assign acc_nxt  = wrap ? FRAC_W'(sum - {1'b0, mod_eff}) : sum[FRAC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; acc <= '0; mod_q <= '0;
      n_out <= '0; carry <= 1'b0; n_strobe <= 1'b0;
    end else if (pwr_dn) begin
      cnt <= '0; acc <= '0; mod_q <= '0;
      n_out <= '0; carry <= 1'b0; n_strobe <= 1'b0;
    end else begin
      n_strobe <= tick;
      if (tick) begin
        cnt   <= '0;
        acc   <= acc_nxt;
        mod_q <= mod_eff;
        n_out <= {1'b0, int_eff} + N_W'(wrap);
        carry <= wrap;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0) |-> (acc < mod_q)); // R3

  AST_PWRDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (acc == '0 && n_out == '0 && !carry && !n_strobe && cnt == '0)); // R10

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
    (!n_strobe && !$past(pwr_dn)) |-> ($stable(n_out) && $stable(carry))); // R8

  AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frac_eff == '0) |=> !carry); // R5

  AST_FULL_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frac_eff == mod_eff) |=> carry); // R6

endmodule

// File: tb/frac_n_seq_bench.sv
module frac_n_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pwr_dn, dbl_en;
  logic [3:0] ref_div;
  logic [7:0] int_in;
  logic [11:0] frac_in, mod_in;
  logic [8:0] n_out;
  logic carry, n_strobe;

  frac_n_seq u_frac_n_seq (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .dbl_en(dbl_en), .ref_div(ref_div),
    .int_in(int_in), .frac_in(frac_in), .mod_in(mod_in),
    .n_out(n_out), .carry(carry), .n_strobe(n_strobe));

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R10";

  int m_cnt = 0, m_acc = 0, m_mod_last = 0;
  int exp_n = 0, exp_c = 0, exp_s = 0;
  int last_i = -1, last_f = -1, last_m = -1;
  bit win_clr = 1'b1;
  int win_tgt = 0, win_mod = 2;
  int q[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    int ie, me, fe, re, p;
    ie = (int'(int_in) < 31) ? 31 : int'(int_in);
    me = (int'(mod_in) < 2) ? 2 : int'(mod_in);
    fe = (int'(frac_in) > me) ? me : int'(frac_in);
    re = (ref_div == 0) ? 1 : int'(ref_div);
    if (!rst_n || pwr_dn) begin
      m_cnt = 0; m_acc = 0; m_mod_last = 0;
      exp_n = 0; exp_c = 0; exp_s = 0;
      last_i = -1; last_f = -1; last_m = -1;
    end else begin
      p = dbl_en ? re : 2 * re;
      exp_s = 0;
      if (m_cnt >= p - 1) begin
        m_cnt = 0;
        if (me != m_mod_last) m_acc = 0;
        m_mod_last = me;
        m_acc = m_acc + fe;
        exp_c = (m_acc >= me) ? 1 : 0;
        if (exp_c == 1) m_acc = m_acc - me;
        exp_n = ie + exp_c;
        exp_s = 1;
        win_clr = (ie != last_i) || (fe != last_f) || (me != last_m);
        last_i = ie; last_f = fe; last_m = me;
        win_tgt = me * ie + fe;
        win_mod = me;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    int s;
    check(n_out == exp_n, tag, "n_out", n_out, exp_n);
    check(carry == exp_c, tag, "carry", carry, exp_c);
    check(n_strobe == exp_s, {tag, " R1"}, "n_strobe", n_strobe, exp_s);
    if (n_strobe && exp_s == 1) begin
      if (win_clr) q.delete();
      q.push_back(int'(n_out));
      if (q.size() == win_mod) begin
        s = 0;
        foreach (q[k]) s += q[k];
        check(s == win_tgt, "R4", "window sum", s, win_tgt);
        void'(q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic prog(input bit d, input int r, input int i, input int f, input int m);
    dbl_en = d; ref_div = 4'(r); int_in = 8'(i); frac_in = 12'(f); mod_in = 12'(m);
  endtask

  task automatic next_strobe();
    @(negedge clk);
    while (!n_strobe) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; pwr_dn = 1'b0;
    prog(1'b0, 3, 100, 3, 7);
    repeat (3) @(negedge clk);
    check(n_out == 0 && !carry && !n_strobe, "R10", "reset outputs", n_out, 0);
    rst_n = 1'b1;
    tag = "R3";
    repeat (400) @(negedge clk);
    tag = "R8";
    next_strobe(); @(negedge clk);
    prog(1'b0, 3, 60, 5, 7);
    repeat (400) @(negedge clk);
    tag = "R5";
    prog(1'b0, 2, 77, 0, 9);
    repeat (100) @(negedge clk);
    next_strobe(); @(negedge clk);
    check(n_out == 77 && !carry, "R5", "frac zero ratio", n_out, 77);
    tag = "R6";
    prog(1'b1, 4, 50, 11, 11);
    repeat (100) @(negedge clk);
    next_strobe();
    check(n_out == 51 && carry, "R6", "full frac ratio", n_out, 51);
    tag = "R9";
    prog(1'b0, 1, 200, 999, 1000);
    repeat (60) @(negedge clk);
    prog(1'b0, 1, 200, 5, 12);
    repeat (200) @(negedge clk);
    tag = "R2";
    prog(1'b1, 0, 40, 3, 5);
    repeat (50) @(negedge clk);
    tag = "R7";
    prog(1'b1, 5, 10, 9, 1);
    repeat (30) @(negedge clk);
    next_strobe();
    check(n_out == 32 && carry, "R7", "clamped ratio", n_out, 32);
    prog(1'b1, 5, 10, 50, 0);
    repeat (30) @(negedge clk);
    prog(1'b1, 2, 90, 50, 9);
    repeat (200) @(negedge clk);
    next_strobe();
    check(n_out == 91 && carry, "R7", "frac clamp", n_out, 91);
    tag = "R10";
    prog(1'b0, 7, 120, 3, 13);
    repeat (37) @(negedge clk);
    pwr_dn = 1'b1;
    repeat (5) @(negedge clk);
    check(n_out == 0 && !carry, "R10", "power-down outputs", n_out, 0);
    pwr_dn = 1'b0;
    repeat (300) @(negedge clk);
    tag = "R4";
    prog(1'b1, 0, 255, 1234, 4095);
    repeat (4300) @(negedge clk);
    rst_n = 1'b0;
    tag = "R10";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule